// File: doc/BRIEF.md
# Alternating-Spacer Dual-Rail Counter

This block is an 8-bit up-counter whose state and datapath are carried entirely on rail pairs. Each bit travels on two wires. A true-rail/false-rail pair of (1,0) means logic 1, (0,1) means logic 0, and an all-equal pair is a spacer that carries no data.

Every operation cycle lasts two clock periods. In the spacer period the register drives all-zero pairs. In the code period it drives the stored count as valid code words. As a result, every output pair flips exactly one wire at every clock edge, whatever the count value is.

The next value comes from a ripple chain of dual-rail full adders built only from negative gates. Because each gate layer inverts the spacer, the spacer alternates between all-zeros and all-ones from one layer to the next. Logical inversion inside a gate is a swap of the two rails. Where a connection joins gates whose depths differ by an even number, a polarity flipper is placed on that connection. The flipper is a pair of crossed inverters. The sum outputs are always brought back to the all-zero spacer before they reach the register. A single-rail mirror of the stored count is provided for checking.

Top module: `spacer_alt_incr`

## Requirements
- R1: While `rst` is high at a rising edge, the stored count is loaded with 0xFC and the next clock period is a spacer period: all of `cnt_t` and `cnt_f` are 0 and `cnt_mirror` is 0xFC.
- R2: Out of reset, spacer periods and code periods alternate on every clock edge. The value shown in each code period is the previous shown value plus one, modulo 256.
- R3: A count of 0xFF is followed by 0x00. The carry out of the top adder stage is code 1 exactly when the shown count is 0xFF, and it is at the all-ones spacer during spacer periods (its depth is odd).
- R4: Bit i of a code word appears as `cnt_t[i]`=value and `cnt_f[i]`=inverse. A pair with both wires high never appears at the ports.
- R5: At every clock edge after the first period out of reset, each output pair changes exactly one of its two wires.
- R6: `cnt_mirror` equals `cnt_t` during code periods. It changes only at the edge that ends a code period.
- R7: During spacer periods every sum pair leaving the adder chain is all-zero. During code periods the sums form the code word for the shown count plus one.
- R8: Raising `rst` during a run, in either period, restarts the sequence from the spacer period holding 0xFC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cnt_t | output | 8 | True rails of the dual-rail count |
| cnt_f | output | 8 | False rails of the dual-rail count |
| cnt_mirror | output | 8 | Single-rail copy of the stored count |

## Verification
The only input besides the clock is `rst`. The properties assume that `rst` is high at the first rising edge and that any later pulse is synchronous and lasts at least one edge. The properties that look one cycle back also assume that the previous edge was not a reset edge. The bench drives `rst` only on falling clock edges and holds it for several edges. It runs long enough to pass through two wraps, and it pulses reset once in the middle of a run, so that every rule about spacer/code alternation is seen both from reset and in steady state.

// File: rtl/sa_pkg.sv
package sa_pkg;

    // One dual-rail bit: t is the true rail, f the false rail.
    typedef struct packed {
        logic t;
        logic f;
    } rail_t;

    typedef enum logic [1:0] {
        OP_AND,
        OP_OR,
        OP_XOR
    } gate_op_e;

    localparam rail_t SP_LO = rail_t'{t: 1'b0, f: 1'b0};
    localparam rail_t SP_HI = rail_t'{t: 1'b1, f: 1'b1};

    function automatic rail_t enc(input logic v);
        return rail_t'{t: v, f: ~v};
    endfunction

    // Spacer seen on a net that leaves a gate at the given depth.
    function automatic rail_t spacer_at(input int depth);
        return ((depth % 2) == 0) ? SP_LO : SP_HI;
    endfunction

    // Logical NOT in dual-rail: exchange the wires, no gate needed.
    function automatic rail_t rail_swap(input rail_t r);
        return rail_t'{t: r.f, f: r.t};
    endfunction

    // Crossed inverter pair: flips spacer polarity, keeps code words.
    function automatic rail_t pol_flip(input rail_t r);
        return rail_t'{t: ~r.f, f: ~r.t};
    endfunction

    function automatic rail_t pos_and(input rail_t a, input rail_t b);
        return rail_t'{t: a.t & b.t, f: a.f | b.f};
    endfunction

    function automatic rail_t pos_or(input rail_t a, input rail_t b);
        return rail_t'{t: a.t | b.t, f: a.f & b.f};
    endfunction

    function automatic rail_t pos_eval(input gate_op_e op, input rail_t a, input rail_t b);
        case (op)
            OP_AND:  return pos_and(a, b);
            OP_OR:   return pos_or(a, b);
            default: return pos_or(pos_and(a, rail_swap(b)), pos_and(rail_swap(a), b));
        endcase
    endfunction

    // Negative form: invert both outputs of the positive gate, then swap them.
    function automatic rail_t neg_eval(input gate_op_e op, input rail_t a, input rail_t b);
        rail_t p;
        p = pos_eval(op, a, b);
        return rail_t'{t: ~p.f, f: ~p.t};
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Depth of the carry entering a stage (stage 0 takes a register-level carry).
    function automatic int carry_depth(input int stage);
        int d;
        d = 0;
        for (int k = 0; k < stage; k++) begin
            d = max2(1, d) + 2;
        end
        return d;
    endfunction

    function automatic int sum_depth(input int stage);
        return max2(1, carry_depth(stage)) + 1;
    endfunction

endpackage

// File: rtl/sa_neg_gate.sv
module sa_neg_gate
    import sa_pkg::*;
#(
    parameter gate_op_e OP      = OP_AND,
    parameter int       DEPTH   = 1,
    parameter int       A_DEPTH = 0,
    parameter int       B_DEPTH = 0
) (
    input  rail_t a,
    input  rail_t b,
    output rail_t y
);
    rail_t a_al;
    rail_t b_al;

    // An even depth gap means the driver's spacer matches this gate's
    // output spacer, not its input spacer: flip polarity on that wire.
    if (((DEPTH - A_DEPTH) % 2) == 0) begin : g_a_flip
        assign a_al = pol_flip(a);
    end else begin : g_a_pass
        assign a_al = a;
    end

    if (((DEPTH - B_DEPTH) % 2) == 0) begin : g_b_flip
        assign b_al = pol_flip(b);
    end else begin : g_b_pass
        assign b_al = b;
    end

    assign y = neg_eval(OP, a_al, b_al);

endmodule

// File: rtl/sa_adder_stage.sv
module sa_adder_stage
    import sa_pkg::*;
#(
    parameter int CI_DEPTH = 0
) (
    input  rail_t a,
    input  rail_t b,
    input  rail_t ci,
    output rail_t s,
    output rail_t co
);
    localparam int X_D  = 1;
    localparam int M_D  = max2(X_D, CI_DEPTH) + 1;
    localparam int CO_D = M_D + 1;

    rail_t x_r;
    rail_t g_r;
    rail_t p_r;
    rail_t s_raw;

    sa_neg_gate #(.OP(OP_XOR), .DEPTH(X_D), .A_DEPTH(0), .B_DEPTH(0)) u_x (
        .a(a), .b(b), .y(x_r)
    );

    sa_neg_gate #(.OP(OP_AND), .DEPTH(X_D), .A_DEPTH(0), .B_DEPTH(0)) u_g (
        .a(a), .b(b), .y(g_r)
    );

    sa_neg_gate #(.OP(OP_XOR), .DEPTH(M_D), .A_DEPTH(X_D), .B_DEPTH(CI_DEPTH)) u_s (
        .a(x_r), .b(ci), .y(s_raw)
    );

    sa_neg_gate #(.OP(OP_AND), .DEPTH(M_D), .A_DEPTH(X_D), .B_DEPTH(CI_DEPTH)) u_p (
        .a(x_r), .b(ci), .y(p_r)
    );

    sa_neg_gate #(.OP(OP_OR), .DEPTH(CO_D), .A_DEPTH(X_D), .B_DEPTH(M_D)) u_co (
        .a(g_r), .b(p_r), .y(co)
    );

    // Sum leaves the datapath: restore the all-zero spacer if needed.
    if ((M_D % 2) != 0) begin : g_s_flip
        assign s = pol_flip(s_raw);
    end else begin : g_s_pass
        assign s = s_raw;
    end

endmodule

// File: rtl/sa_ripple_chain.sv
module sa_ripple_chain
    import sa_pkg::*;
#(
    parameter int W = 8
) (
    input  rail_t [W-1:0] a,
    input  rail_t [W-1:0] b,
    input  rail_t         ci,
    output rail_t [W-1:0] s,
    output rail_t         co
);
    rail_t [W:0] c;

    assign c[0] = ci;

    for (genvar i = 0; i < W; i++) begin : g_stage
        sa_adder_stage #(.CI_DEPTH(carry_depth(i))) u_fa (
            .a (a[i]),
            .b (b[i]),
            .ci(c[i]),
            .s (s[i]),
            .co(c[i+1])
        );
    end

    assign co = c[W];

endmodule

// File: rtl/sa_rail_reg.sv
module sa_rail_reg
    import sa_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = 8'hFC
) (
    input  logic          clk,
    input  logic          rst,
    input  rail_t [W-1:0] d,
    output rail_t [W-1:0] q,
    output logic          code_phase,
    output logic [W-1:0]  mirror
);
    rail_t [W-1:0] store;

    always_ff @(posedge clk) begin
        if (rst) begin
            code_phase <= 1'b0;
            for (int i = 0; i < W; i++) begin
                store[i] <= enc(INIT[i]);
            end
        end else begin
            code_phase <= ~code_phase;
            if (code_phase) begin
                store <= d;
            end
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        assign q[i]      = code_phase ? store[i] : SP_LO;
        assign mirror[i] = store[i].t;
    end

endmodule

// File: rtl/spacer_alt_incr.sv
module spacer_alt_incr
    import sa_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = 8'hFC,
    parameter logic [W-1:0] STEP = 8'h01
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] cnt_t,
    output logic [W-1:0] cnt_f,
    output logic [W-1:0] cnt_mirror
);
    rail_t [W-1:0] reg_q;
    rail_t [W-1:0] addend;
    rail_t [W-1:0] sum_rails;
    rail_t         carry_in;
    rail_t         carry_out;
    logic          code_phase;

    sa_rail_reg #(.W(W), .INIT(INIT)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .d         (sum_rails),
        .q         (reg_q),
        .code_phase(code_phase),
        .mirror    (cnt_mirror)
    );

    // Constant operands follow the same spacer/code rhythm as the register.
    for (genvar i = 0; i < W; i++) begin : g_addend
        assign addend[i] = code_phase ? enc(STEP[i]) : SP_LO;
        assign cnt_t[i]  = reg_q[i].t;
        assign cnt_f[i]  = reg_q[i].f;
    end

    assign carry_in = code_phase ? enc(1'b0) : SP_LO;

    sa_ripple_chain #(.W(W)) u_chain (
        .a (reg_q),
        .b (addend),
        .ci(carry_in),
        .s (sum_rails),
        .co(carry_out)
    );

endmodule

// File: rtl/spacer_alt_incr_chk.sv
module spacer_alt_incr_chk
    import sa_pkg::*;
#(
    parameter int           W    = 8,
    parameter logic [W-1:0] INIT = 8'hFC,
    parameter logic [W-1:0] STEP = 8'h01
) (
    input logic          clk,
    input logic          rst,
    input logic [W-1:0]  cnt_t,
    input logic [W-1:0]  cnt_f,
    input logic [W-1:0]  cnt_mirror,
    input rail_t [W-1:0] sum_rails,
    input rail_t         carry_out
);
    localparam rail_t CO_SP = spacer_at(carry_depth(W));

    logic [W-1:0] sum_t;
    logic [W-1:0] sum_f;
    logic [W:0]   wide;
    logic         out_spacer;
    logic         out_code;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            sum_t[i] = sum_rails[i].t;
            sum_f[i] = sum_rails[i].f;
        end
    end

    assign wide       = {1'b0, cnt_mirror} + {1'b0, STEP};
    assign out_spacer = ((cnt_t | cnt_f) == '0);
    assign out_code   = ((cnt_t ^ cnt_f) == '1);

    // R1 and R8: every reset release starts in a spacer period holding INIT
    a_r1_reset_load: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (out_spacer && cnt_mirror == INIT));

    a_r2_spacer_then_code: assert property (@(posedge clk) disable iff (rst)
        out_spacer |=> out_code);

    a_r2_code_then_spacer: assert property (@(posedge clk) disable iff (rst)
        out_code |=> out_spacer);

    a_r4_legal_pairs: assert property (@(posedge clk) disable iff (rst)
        (cnt_t & cnt_f) == '0);

    a_r5_one_wire_per_pair: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((cnt_t ^ $past(cnt_t)) ^ (cnt_f ^ $past(cnt_f))) == '1));

    a_r6_mirror_in_code: assert property (@(posedge clk) disable iff (rst)
        out_code |-> cnt_t == cnt_mirror);

    a_r6_mirror_hold: assert property (@(posedge clk) disable iff (rst)
        out_spacer |=> $stable(cnt_mirror));

    a_r7_sum_spacer: assert property (@(posedge clk) disable iff (rst)
        out_spacer |-> (sum_t == '0 && sum_f == '0));

    a_r7_sum_value: assert property (@(posedge clk) disable iff (rst)
        out_code |-> ((sum_t ^ sum_f) == '1 && sum_t == wide[W-1:0]));

    a_r3_carry_spacer: assert property (@(posedge clk) disable iff (rst)
        out_spacer |-> carry_out == CO_SP);

    a_r3_carry_code: assert property (@(posedge clk) disable iff (rst)
        out_code |-> carry_out == enc(wide[W]));

endmodule

bind spacer_alt_incr spacer_alt_incr_chk #(.W(W), .INIT(INIT), .STEP(STEP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_t     (cnt_t),
    .cnt_f     (cnt_f),
    .cnt_mirror(cnt_mirror),
    .sum_rails (sum_rails),
    .carry_out (carry_out)
);

// File: tb/spacer_alt_incr_tb_top.sv
module spacer_alt_incr_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cnt_t;
    logic [7:0] cnt_f;
    logic [7:0] cnt_mirror;

    int         n_checks = 0;
    int         n_fail   = 0;
    logic [7:0] ref_val;
    logic       exp_code;

    always #5 clk = ~clk;

    spacer_alt_incr dut_i (
        .clk       (clk),
        .rst       (rst),
        .cnt_t     (cnt_t),
        .cnt_f     (cnt_f),
        .cnt_mirror(cnt_mirror)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Leaves the bench in the first spacer period after release.
    task automatic do_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 spacer true rails", {24'd0, cnt_t}, 32'h00);
        chk("R1 spacer false rails", {24'd0, cnt_f}, 32'h00);
        chk("R1 mirror init", {24'd0, cnt_mirror}, 32'hFC);
        step();
        chk("R4 code true rails", {24'd0, cnt_t}, 32'hFC);
        chk("R4 code false rails", {24'd0, cnt_f}, 32'h03);
        chk("R1 mirror in first code", {24'd0, cnt_mirror}, 32'hFC);
        ref_val  = 8'hFC;
        exp_code = 1'b1;
    endtask

    // Runs n clock periods starting from the current one.
    task automatic t_count_run(input int n);
        logic [7:0] pt;
        logic [7:0] pf;
        for (int k = 0; k < n; k++) begin
            pt = cnt_t;
            pf = cnt_f;
            step();
            exp_code = ~exp_code;
            chk("R5 one wire per pair", {24'd0, (cnt_t ^ pt) ^ (cnt_f ^ pf)}, 32'hFF);
            chk("R5 no double toggle", {24'd0, (cnt_t ^ pt) & (cnt_f ^ pf)}, 32'h00);
            if (exp_code) begin
                chk("R2 R7 code value", {24'd0, cnt_t}, {24'd0, ref_val});
                chk("R4 false rails", {24'd0, cnt_f}, {24'd0, ~ref_val});
                chk("R6 mirror in code", {24'd0, cnt_mirror}, {24'd0, ref_val});
            end else begin
                ref_val = ref_val + 8'd1;
                chk("R2 spacer period", {24'd0, cnt_t | cnt_f}, 32'h00);
                chk("R6 mirror after capture", {24'd0, cnt_mirror}, {24'd0, ref_val});
            end
        end
    endtask

    task automatic t_wrap();
        t_reset_state();
        t_count_run(6);
        chk("R3 shows FF", {24'd0, cnt_t}, 32'hFF);
        step();
        chk("R3 mirror wraps", {24'd0, cnt_mirror}, 32'h00);
        chk("R3 spacer before 00", {24'd0, cnt_t | cnt_f}, 32'h00);
        step();
        chk("R3 true rails 00", {24'd0, cnt_t}, 32'h00);
        chk("R3 false rails FF", {24'd0, cnt_f}, 32'hFF);
        ref_val  = 8'h00;
        exp_code = 1'b1;
    endtask

    task automatic t_midrun_reset();
        t_count_run(9);
        rst = 1'b1;
        step();
        chk("R8 spacer under reset", {24'd0, cnt_t | cnt_f}, 32'h00);
        chk("R8 mirror reloaded", {24'd0, cnt_mirror}, 32'hFC);
        step();
        rst = 1'b0;
        chk("R8 spacer after release", {24'd0, cnt_t | cnt_f}, 32'h00);
        step();
        chk("R8 code FC", {24'd0, cnt_t}, 32'hFC);
        chk("R8 false rails", {24'd0, cnt_f}, 32'h03);
        ref_val  = 8'hFC;
        exp_code = 1'b1;
        t_count_run(10);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_count_run(600);
        t_wrap();
        t_midrun_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog act=expired exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule